// File: doc/BRIEF.md
# Converter Power and Clock-Mode Controller

This block decides when the analog parts of a serial sampling converter are powered, which clock paces each conversion, and how the reference buffer is compensated. It reads the two power/clock bits that arrive with each control byte, a wake pulse raised when a start bit is seen, a conversion-done pulse, and a three-level hardware shutdown pin that arrives as a 2-bit code. It drives enables for the bandgap and for the rest of the analog chain, a clock-mode flag, a compensation-mode flag, a ready flag and a launch pulse for the conversion engine.

A software power-down only takes hold once the conversion it came with has finished. A hardware shutdown acts in the same cycle and aborts any conversion in flight. Any start bit wakes the block, and the warm-up delay depends on how deeply it was asleep and on the compensation mode. All delays are counted in system clocks by a loadable down-counter, and ready stays low until it runs out.

Top module: `conv_pwr_ctrl`

## Requirements
- R1: While reset is held with the shutdown code at 01, the outputs are: iface_en 1 and all other outputs 0.
- R2: After reset, or when shutdown is released, ready rises on the (RST_CYC+2)-th rising edge counted from the first edge at which shutdown is inactive, with clk_ext 0 (internal clock) and no conversion launched.
- R3: The power bits of a command (pd[1:0]) select: 11 external clock, 10 internal clock, 01 fast power-down, 00 full power-down. For 11 and 10, clk_ext takes pd[0] on the edge after conv_go and the block stays powered after conv_done.
- R4: For pd 01 or 00, clk_ext keeps its previous value, and the block stays fully powered until conv_done; the edge that samples conv_done enters the requested power-down.
- R5: In fast power-down bg_en is 1 and ana_en 0; in full power-down both are 0; iface_en stays 1 in both; ana_en never is 1 without bg_en.
- R6: start_det or cmd_valid while powered down starts warm-up; ready rises on the (D+2)-th edge counted from the edge that samples the wake, where D is FAST_INT, FAST_EXT, FULL_INT or FULL_EXT by the prior power-down depth and comp_ext.
- R7: A command received while powered down is kept and conv_go is raised in the same cycle that ready rises.
- R8: Shutdown active drops iface_en, bg_en, ana_en and ready in the same cycle, and conv_abort is 1 in that cycle when a conversion is running; conv_abort is 0 from the next edge.
- R9: Shutdown code 00 is shutdown, 01 is active with internal compensation (comp_ext 0), 10 is active with external compensation (comp_ext 1), 11 is treated as shutdown.
- R10: Commands and conv_done received during shutdown are discarded: after release no conversion is launched.
- R11: conv_go is only 1 while ready is 1, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_code | input | 2 | Shutdown pin level: 00 low, 01 high, 10 floating, 11 illegal |
| start_det | input | 1 | Pulse: start bit detected |
| cmd_valid | input | 1 | Pulse: control byte complete, cmd_pd valid |
| cmd_pd | input | 2 | Power/clock bits of the control byte |
| conv_done | input | 1 | Pulse: conversion engine finished |
| iface_en | output | 1 | Serial interface enabled |
| bg_en | output | 1 | Bandgap power enable |
| ana_en | output | 1 | Analog chain power enable |
| ready | output | 1 | Powered and settled |
| clk_ext | output | 1 | 1 = conversion paced by serial clock, 0 = internal clock |
| comp_ext | output | 1 | 1 = external reference compensation |
| conv_go | output | 1 | Pulse: launch the stored conversion |
| conv_abort | output | 1 | Running conversion cut off by shutdown |

## Verification
A wrong power state shows at bg_en, ana_en and ready on the edge after the offending stimulus, so every transition is followed by a full output compare one cycle later. A wrong delay selection or counter load shows only as a ready edge arriving early or late, which is why each of the five warm-up paths is measured as an exact edge count. A lost or stale stored command shows as a missing or spurious conv_go when ready rises, and a wrong stored clock mode shows at clk_ext one edge after launch.

// File: rtl/conv_pwr_pkg.sv
`timescale 1ns/1ps
package conv_pwr_pkg;
  typedef enum logic [2:0] {
    ST_SHDN = 3'd0,
    ST_OFF  = 3'd1,
    ST_FAST = 3'd2,
    ST_WARM = 3'd3,
    ST_ON   = 3'd4
  } pwr_st_e;

  localparam logic [1:0] SHDN_LOW   = 2'b00;
  localparam logic [1:0] SHDN_HIGH  = 2'b01;
  localparam logic [1:0] SHDN_FLOAT = 2'b10;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/conv_pwr_shdn_dec.sv
`timescale 1ns/1ps
module conv_pwr_shdn_dec
  import conv_pwr_pkg::*;
(
  input  logic [1:0] shdn_code,
  output logic       shdn_act,
  output logic       comp_ext
);
  // Active levels are decoded explicitly; anything else shuts down.
  always_comb begin
    shdn_act = 1'b1;
    comp_ext = 1'b0;
    case (shdn_code)
      SHDN_HIGH:  shdn_act = 1'b0;
      SHDN_FLOAT: begin
        shdn_act = 1'b0;
        comp_ext = 1'b1;
      end
      default:    shdn_act = 1'b1;
    endcase
  end
endmodule

// File: rtl/conv_pwr_timer.sv
`timescale 1ns/1ps
module conv_pwr_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/conv_pwr_fsm.sv
`timescale 1ns/1ps
module conv_pwr_fsm
  import conv_pwr_pkg::*;
#(
  parameter int CW         = 5,
  parameter int RST_CYC    = 20,
  parameter int FAST_INT   = 3,
  parameter int FAST_EXT   = 6,
  parameter int FULL_INT   = 10,
  parameter int FULL_EXT   = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shdn_act,
  input  logic          comp_ext,
  input  logic          start_det,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_pd,
  input  logic          conv_done,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          bg_en,
  output logic          ana_en,
  output logic          ready,
  output logic          clk_ext,
  output logic          conv_go,
  output logic          conv_abort
);
  localparam logic [CW-1:0] L_RST      = CW'(RST_CYC);
  localparam logic [CW-1:0] L_FAST_INT = CW'(FAST_INT);
  localparam logic [CW-1:0] L_FAST_EXT = CW'(FAST_EXT);
  localparam logic [CW-1:0] L_FULL_INT = CW'(FULL_INT);
  localparam logic [CW-1:0] L_FULL_EXT = CW'(FULL_EXT);

  pwr_st_e    st_q, st_d;
  logic       busy_q, busy_d;
  logic       pend_q, pend_d;
  logic [1:0] pd_q, pd_d;
  logic       defer_q, defer_d;
  logic       dfast_q, dfast_d;
  logic       clk_q, clk_d;
  logic       wake_req;
  logic [CW-1:0] wake_val;

  assign wake_req = start_det | cmd_valid;
  assign wake_val = (st_q == ST_FAST) ? (comp_ext ? L_FAST_EXT : L_FAST_INT)
                                      : (comp_ext ? L_FULL_EXT : L_FULL_INT);

  assign ready      = ~shdn_act & (st_q == ST_ON);
  assign ana_en     = ~shdn_act & ((st_q == ST_ON) | (st_q == ST_WARM));
  assign bg_en      = ~shdn_act & ((st_q == ST_ON) | (st_q == ST_WARM) |
                                   (st_q == ST_FAST));
  assign conv_go    = ready & pend_q & ~busy_q;
  assign conv_abort = shdn_act & busy_q;
  assign clk_ext    = clk_q;

  always_comb begin
    st_d     = st_q;
    busy_d   = busy_q;
    pend_d   = pend_q;
    pd_d     = pd_q;
    defer_d  = defer_q;
    dfast_d  = dfast_q;
    clk_d    = clk_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (shdn_act) begin
      st_d    = ST_SHDN;
      busy_d  = 1'b0;
      pend_d  = 1'b0;
      defer_d = 1'b0;
    end else begin
      case (st_q)
        ST_SHDN: begin
          st_d     = ST_WARM;
          tmr_load = 1'b1;
          tmr_val  = L_RST;
          clk_d    = 1'b0;
        end
        ST_OFF, ST_FAST: begin
          if (wake_req) begin
            st_d     = ST_WARM;
            tmr_load = 1'b1;
            tmr_val  = wake_val;
          end
        end
        ST_WARM: begin
          if (tmr_expired) st_d = ST_ON;
        end
        ST_ON: begin
          if (conv_go) begin
            busy_d  = 1'b1;
            pend_d  = 1'b0;
            defer_d = ~pd_q[1];
            dfast_d = pd_q[0];
            if (pd_q[1]) clk_d = pd_q[0];
          end
          if (busy_q && conv_done) begin
            busy_d  = 1'b0;
            defer_d = 1'b0;
            if (defer_q) st_d = dfast_q ? ST_FAST : ST_OFF;
          end
        end
        default: st_d = ST_SHDN;
      endcase
      if (cmd_valid) begin
        pend_d = 1'b1;
        pd_d   = cmd_pd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_SHDN;
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      pd_q    <= 2'b00;
      defer_q <= 1'b0;
      dfast_q <= 1'b0;
      clk_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      busy_q  <= busy_d;
      pend_q  <= pend_d;
      pd_q    <= pd_d;
      defer_q <= defer_d;
      dfast_q <= dfast_d;
      clk_q   <= clk_d;
    end
  end
endmodule

// File: rtl/conv_pwr_ctrl.sv
`timescale 1ns/1ps
module conv_pwr_ctrl
  import conv_pwr_pkg::*;
#(
  parameter int RST_CYC  = 20,
  parameter int FAST_INT = 3,
  parameter int FAST_EXT = 6,
  parameter int FULL_INT = 10,
  parameter int FULL_EXT = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] shdn_code,
  input  logic       start_det,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_pd,
  input  logic       conv_done,
  output logic       iface_en,
  output logic       bg_en,
  output logic       ana_en,
  output logic       ready,
  output logic       clk_ext,
  output logic       comp_ext,
  output logic       conv_go,
  output logic       conv_abort
);
  localparam int MAXD = max2(max2(RST_CYC, max2(FAST_INT, FAST_EXT)),
                             max2(FULL_INT, FULL_EXT));
  localparam int CW   = $clog2(MAXD + 1) + 1;

  logic          shdn_act;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;

  conv_pwr_shdn_dec u_dec (
    .shdn_code (shdn_code),
    .shdn_act  (shdn_act),
    .comp_ext  (comp_ext)
  );

  conv_pwr_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  conv_pwr_fsm #(
    .CW(CW), .RST_CYC(RST_CYC), .FAST_INT(FAST_INT), .FAST_EXT(FAST_EXT),
    .FULL_INT(FULL_INT), .FULL_EXT(FULL_EXT)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .shdn_act    (shdn_act),
    .comp_ext    (comp_ext),
    .start_det   (start_det),
    .cmd_valid   (cmd_valid),
    .cmd_pd      (cmd_pd),
    .conv_done   (conv_done),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .bg_en       (bg_en),
    .ana_en      (ana_en),
    .ready       (ready),
    .clk_ext     (clk_ext),
    .conv_go     (conv_go),
    .conv_abort  (conv_abort)
  );

  assign iface_en = ~shdn_act;
endmodule

// File: rtl/conv_pwr_ctrl_chk.sv
`timescale 1ns/1ps
module conv_pwr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic iface_en,
  input logic bg_en,
  input logic ana_en,
  input logic ready,
  input logic clk_ext,
  input logic conv_go,
  input logic conv_abort
);
  assert_go_when_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |-> ready);

  assert_single_launch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |=> !conv_go);

  assert_ana_needs_bg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ana_en |-> bg_en);

  assert_shdn_cuts_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !iface_en |-> (!bg_en && !ana_en && !ready));

  assert_abort_only_in_shdn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> !iface_en);

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(conv_go) && $past(bg_en)) |-> $stable(clk_ext));
endmodule

bind conv_pwr_ctrl conv_pwr_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iface_en   (iface_en),
  .bg_en      (bg_en),
  .ana_en     (ana_en),
  .ready      (ready),
  .clk_ext    (clk_ext),
  .conv_go    (conv_go),
  .conv_abort (conv_abort)
);

// File: tb/conv_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module conv_pwr_ctrl_tb;
  localparam int RST_CYC  = 20;
  localparam int FAST_INT = 3;
  localparam int FAST_EXT = 6;
  localparam int FULL_INT = 10;
  localparam int FULL_EXT = 15;

  logic       clk;
  logic       rst_n;
  logic [1:0] shdn_code;
  logic       start_det, cmd_valid, conv_done;
  logic [1:0] cmd_pd;
  logic       iface_en, bg_en, ana_en, ready, clk_ext, comp_ext, conv_go, conv_abort;

  typedef struct {
    string tag;
    bit    is_cnt;
    int    exp;
    int    cnt;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  conv_pwr_ctrl #(
    .RST_CYC(RST_CYC), .FAST_INT(FAST_INT), .FAST_EXT(FAST_EXT),
    .FULL_INT(FULL_INT), .FULL_EXT(FULL_EXT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .shdn_code(shdn_code), .start_det(start_det),
    .cmd_valid(cmd_valid), .cmd_pd(cmd_pd), .conv_done(conv_done),
    .iface_en(iface_en), .bg_en(bg_en), .ana_en(ana_en), .ready(ready),
    .clk_ext(clk_ext), .comp_ext(comp_ext), .conv_go(conv_go),
    .conv_abort(conv_abort)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Output vector: {iface_en,bg_en,ana_en,ready,clk_ext,comp_ext,conv_go,conv_abort}
  function automatic int outs();
    return int'({iface_en, bg_en, ana_en, ready, clk_ext, comp_ext, conv_go, conv_abort});
  endfunction

  // Monitor: pops expected items and compares
  initial begin
    forever begin
      wait (q.size() != 0);
      #1;
      begin
        item_t it;
        int act;
        it = q.pop_front();
        act = it.is_cnt ? it.cnt : outs();
        n_cmp++;
        if (act != it.exp) begin
          n_bad++;
          if (it.is_cnt)
            $display("FAIL %s: actual %0d expected %0d", it.tag, act, it.exp);
          else
            $display("FAIL %s: actual %08b expected %08b", it.tag, act[7:0], it.exp[7:0]);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] e);
    item_t it;
    it.tag = tag; it.is_cnt = 1'b0; it.exp = int'(e); it.cnt = 0;
    q.push_back(it);
    #3;
  endtask

  task automatic chk_cnt(input string tag, input int e, input int n);
    item_t it;
    it.tag = tag; it.is_cnt = 1'b1; it.exp = e; it.cnt = n;
    q.push_back(it);
    #3;
  endtask

  task automatic nb();
    @(negedge clk);
  endtask

  // Command pulse; returns at the negedge where conv_go is expected
  task automatic cmd(input logic [1:0] pd);
    nb(); cmd_valid = 1'b1; cmd_pd = pd;
    nb(); cmd_valid = 1'b0;
  endtask

  task automatic done_pulse();
    nb(); conv_done = 1'b1;
    nb(); conv_done = 1'b0;
  endtask

  // Counts rising edges from the stimulus until ready is seen high
  task automatic count_ready(input string tag, input int e);
    int n;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      start_det = 1'b0; cmd_valid = 1'b0;
    end while (!ready && n < 1000);
    chk_cnt(tag, e, n);
  endtask

  task automatic wake(input string tag, input int e, input bit with_cmd, input logic [1:0] pd);
    nb();
    start_det = 1'b1;
    if (with_cmd) begin cmd_valid = 1'b1; cmd_pd = pd; end
    count_ready(tag, e);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; shdn_code = 2'b01; start_det = 1'b0; cmd_valid = 1'b0;
    cmd_pd = 2'b00; conv_done = 1'b0;
    repeat (3) nb();
    chk("R1 reset outputs", 8'b1000_0000);

    // R2: reset interval
    rst_n = 1'b1;
    count_ready("R2 reset interval", RST_CYC + 2);
    chk("R2 settled after reset", 8'b1111_0000);

    // R3: external clock, stays powered
    cmd(2'b11);
    chk("R3 launch pd=11", 8'b1111_0010);
    nb(); chk("R3 external clock selected", 8'b1111_1000);
    done_pulse();
    chk("R3 powered after done", 8'b1111_1000);

    // R4/R5: fast power-down deferred
    cmd(2'b01);
    chk("R11 launch pd=01", 8'b1111_1010);
    nb(); chk("R4 still powered, mode kept", 8'b1111_1000);
    done_pulse();
    chk("R5 fast power-down", 8'b1100_1000);

    // R6/R7: wake from fast, internal comp, with internal-clock command
    wake("R6 fast/internal delay", FAST_INT + 2, 1'b1, 2'b10);
    chk("R7 launch at ready", 8'b1111_1010);
    nb(); chk("R3 internal clock selected", 8'b1111_0000);
    done_pulse();

    // R9: floating -> external compensation
    nb(); shdn_code = 2'b10;
    chk("R9 floating gives external comp", 8'b1111_0100);
    cmd(2'b00);
    chk("R11 launch pd=00", 8'b1111_0110);
    nb(); chk("R4 powered during conversion", 8'b1111_0100);
    done_pulse();
    chk("R5 full power-down", 8'b1000_0100);
    wake("R6 full/external delay", FULL_EXT + 2, 1'b0, 2'b00);
    chk("R6 settled", 8'b1111_0100);

    cmd(2'b01); nb(); done_pulse();
    chk("R5 fast power-down ext comp", 8'b1100_0100);
    wake("R6 fast/external delay", FAST_EXT + 2, 1'b0, 2'b00);

    nb(); shdn_code = 2'b01;
    cmd(2'b00); nb(); done_pulse();
    chk("R5 full power-down int comp", 8'b1000_0000);
    wake("R6 full/internal delay", FULL_INT + 2, 1'b0, 2'b00);

    // R8: shutdown cuts a running conversion
    cmd(2'b11);
    chk("R11 launch before shutdown", 8'b1111_0010);
    nb(); chk("R3 busy external", 8'b1111_1000);
    nb(); shdn_code = 2'b00;
    chk("R8 immediate cut and abort", 8'b0000_1001);
    nb(); chk("R8 abort cleared", 8'b0000_1000);

    // R9/R10: commands ignored, illegal code stays shut down
    cmd_valid = 1'b1; cmd_pd = 2'b11; conv_done = 1'b1;
    nb(); cmd_valid = 1'b0; conv_done = 1'b0; shdn_code = 2'b11;
    chk("R9 illegal code is shutdown", 8'b0000_1000);
    nb(); chk("R9 illegal code held", 8'b0000_1000);

    nb(); shdn_code = 2'b01;
    count_ready("R2 release interval", RST_CYC + 2);
    chk("R10 no stale launch after release", 8'b1111_0000);
    nb(); chk("R10 still idle", 8'b1111_0000);

    summary();
  end
endmodule